// File: doc/BRIEF.md
# Dual Audio Clock Prescaler

This block derives two slow audio clocks from one master clock. An 8-bit configuration word holds two 4-bit division codes, one for each output lane. Each code selects a division factor from a fixed table that is not linear. Codes 0 to 7 give the even factors 2 to 16, which have a 50% duty cycle. Code 8 gives factor 1. Codes 9 to 11 give the odd factors 3, 5 and 7, which have an unequal duty cycle. Codes 12 to 15 are not valid.

Each lane drives three registered outputs, all in the master clock domain. The first is a divided clock level, used as a clock-enable style signal. The second is a one-cycle strobe on the first cycle of every output period. The third is a flag that is set while a code that is not valid is in force. A lane reads a new code only at a period boundary, so a change in configuration never cuts a period short. The configuration is a plain control input. There is no data stream and no handshake.

Top module: `audio_clk_prescaler`

## Requirements
- R1: While the synchronous active-low reset is held, every output is 0.
- R2: Lane A takes its code from configuration bits 7:4 and lane B from bits 3:0. Each lane runs independently of the other.
- R3: Codes 0 to 7 divide by 2×(code+1). In each period the output is high for the first half of the cycles and low for the second half.
- R4: Code 8 divides by 1. The output stays high and the strobe is high on every cycle.
- R5: Codes 9, 10 and 11 divide by 3, 5 and 7. For a factor N, the output is high for the first (N-1)/2 cycles of each period and low for the rest.
- R6: A code from 12 to 15 holds that lane's output and strobe low and sets its flag. The lane reads its code again on every clock until a valid code appears. The flag clears on the first cycle of the new period.
- R7: A lane reads its code only at the clock edge that ends its current period, or at any edge while it is idle (after reset, or while a code that is not valid is in force). A code change in the middle of a period has no effect on the period that is running.
- R8: The strobe is high on exactly the first cycle of each period. On that cycle the output is also high. The output never rises without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_cfg | input | 8 | Division codes: lane A in bits 7:4, lane B in bits 3:0 |
| aclk_a | output | 1 | Lane A divided clock level |
| aclk_a_rise | output | 1 | Lane A strobe on the first cycle of each period |
| aclk_a_bad | output | 1 | Lane A flag: code not valid |
| aclk_b | output | 1 | Lane B divided clock level |
| aclk_b_rise | output | 1 | Lane B strobe on the first cycle of each period |
| aclk_b_bad | output | 1 | Lane B flag: code not valid |

## Verification
A code that a lane reads at a clock edge shapes its outputs in the cycle that follows. The first new period starts one register stage after that edge. Every later position in the period moves forward one cycle per clock.

The bench holds a behavioural model of each lane: a position in the period and a factor, both integers. The model advances at each rising edge from the same configuration value that the design reads. All six outputs are compared with the model at the falling edge, so each check samples a settled value and needs no extra cycle of lag.

Directed counts of high cycles per period confirm the duty rules for the odd factors and for factor 1.

// File: rtl/audio_presc_pkg.sv
package audio_presc_pkg;
  localparam int CODE_W  = 4;
  localparam int MAX_DIV = 16;
  localparam int FACT_W  = $clog2(MAX_DIV) + 1;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int LANES   = 2;
  localparam int CFG_W   = LANES * CODE_W;

  // Map a division code to its factor; 0 marks an unusable code.
  function automatic logic [FACT_W-1:0] code_to_factor(input logic [CODE_W-1:0] c);
    logic [FACT_W-1:0] f;
    if (!c[CODE_W-1]) begin
      f = (FACT_W'(c[CODE_W-2:0]) + FACT_W'(1)) << 1;
    end else if (c[CODE_W-2]) begin
      f = '0;
    end else begin
      f = FACT_W'({c[1:0], 1'b1});
    end
    return f;
  endfunction

  // Cycles spent high in one period of the given factor.
  function automatic logic [FACT_W-1:0] high_cycles(input logic [FACT_W-1:0] f);
    return (f == FACT_W'(1)) ? FACT_W'(1) : (f >> 1);
  endfunction
endpackage

// File: rtl/presc_code_decode.sv
module presc_code_decode
  import audio_presc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [FACT_W-1:0] factor,
  output logic [FACT_W-1:0] high_len,
  output logic              bad
);
  always_comb begin
    factor   = code_to_factor(code);
    high_len = high_cycles(factor);
    bad      = (factor == '0);
  end
endmodule

// File: rtl/presc_lane.sv
module presc_lane
  import audio_presc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              lvl,
  output logic              rise,
  output logic              bad
);
  logic [FACT_W-1:0] dec_factor, dec_high;
  logic              dec_bad;

  presc_code_decode u_dec (
    .code     (code),
    .factor   (dec_factor),
    .high_len (dec_high),
    .bad      (dec_bad)
  );

  logic              act_vld, nxt_vld;
  logic [FACT_W-1:0] act_factor, nxt_factor;
  logic [FACT_W-1:0] act_high, nxt_high;
  logic [CNT_W-1:0]  cnt, nxt_cnt;
  logic              boundary;

  always_comb begin
    boundary   = !act_vld || ({1'b0, cnt} == (act_factor - FACT_W'(1)));
    nxt_vld    = act_vld;
    nxt_factor = act_factor;
    nxt_high   = act_high;
    nxt_cnt    = cnt + CNT_W'(1);
    if (boundary) begin
      nxt_vld    = !dec_bad;
      nxt_factor = dec_factor;
      nxt_high   = dec_high;
      nxt_cnt    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vld    <= 1'b0;
      act_factor <= '0;
      act_high   <= '0;
      cnt        <= '0;
      lvl        <= 1'b0;
      rise       <= 1'b0;
      bad        <= 1'b0;
    end else begin
      act_vld    <= nxt_vld;
      act_factor <= nxt_factor;
      act_high   <= nxt_high;
      cnt        <= nxt_cnt;
      lvl        <= nxt_vld && ({1'b0, nxt_cnt} < nxt_high);
      rise       <= nxt_vld && (nxt_cnt == '0);
      bad        <= !nxt_vld;
    end
  end
endmodule

// File: rtl/audio_clk_prescaler.sv
module audio_clk_prescaler
  import audio_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] presc_cfg,
  output logic             aclk_a,
  output logic             aclk_a_rise,
  output logic             aclk_a_bad,
  output logic             aclk_b,
  output logic             aclk_b_rise,
  output logic             aclk_b_bad
);
  logic [LANES-1:0] lvl_v, rise_v, bad_v;

  // Lane 0 (A) owns the upper code field, lane 1 (B) the lower one.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    presc_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (presc_cfg[(LANES-1-g)*CODE_W +: CODE_W]),
      .lvl   (lvl_v[g]),
      .rise  (rise_v[g]),
      .bad   (bad_v[g])
    );
  end

  assign aclk_a      = lvl_v[0];
  assign aclk_a_rise = rise_v[0];
  assign aclk_a_bad  = bad_v[0];
  assign aclk_b      = lvl_v[1];
  assign aclk_b_rise = rise_v[1];
  assign aclk_b_bad  = bad_v[1];
endmodule

// File: rtl/audio_clk_prescaler_chk.sv
module audio_clk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] presc_cfg,
  input logic       aclk_a,
  input logic       aclk_a_rise,
  input logic       aclk_a_bad,
  input logic       aclk_b,
  input logic       aclk_b_rise,
  input logic       aclk_b_bad
);
  p_rise_high_r8_a: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_a_rise |-> aclk_a);
  p_rise_high_r8_b: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_b_rise |-> aclk_b);
  p_edge_strobe_r8_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aclk_a) |-> aclk_a_rise);
  p_edge_strobe_r8_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aclk_b) |-> aclk_b_rise);
  p_bad_quiet_r6_a: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_a_bad |-> (!aclk_a && !aclk_a_rise));
  p_bad_quiet_r6_b: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_b_bad |-> (!aclk_b && !aclk_b_rise));
  p_bad_field_r2_a: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_a_bad |-> ($past(presc_cfg[7:4]) >= 4'd12));
  p_bad_field_r2_b: assert property (@(posedge clk) disable iff (!rst_n)
    aclk_b_bad |-> ($past(presc_cfg[3:0]) >= 4'd12));
  p_bad_exit_r6_a: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aclk_a_bad) |-> aclk_a_rise);
  p_bad_exit_r6_b: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aclk_b_bad) |-> aclk_b_rise);
endmodule

bind audio_clk_prescaler audio_clk_prescaler_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .presc_cfg   (presc_cfg),
  .aclk_a      (aclk_a),
  .aclk_a_rise (aclk_a_rise),
  .aclk_a_bad  (aclk_a_bad),
  .aclk_b      (aclk_b),
  .aclk_b_rise (aclk_b_rise),
  .aclk_b_bad  (aclk_b_bad)
);

// File: tb/test_audio_clk_prescaler.sv
`timescale 1ns/1ps
module test_audio_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc_cfg = 8'h00;
  logic       aclk_a, aclk_a_rise, aclk_a_bad;
  logic       aclk_b, aclk_b_rise, aclk_b_bad;

  always #2.5 clk = ~clk;

  audio_clk_prescaler i_audio_clk_prescaler (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_cfg   (presc_cfg),
    .aclk_a      (aclk_a),
    .aclk_a_rise (aclk_a_rise),
    .aclk_a_bad  (aclk_a_bad),
    .aclk_b      (aclk_b),
    .aclk_b_rise (aclk_b_rise),
    .aclk_b_bad  (aclk_b_bad)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Factor table taken from the requirements (R3, R4, R5, R6); 0 = not valid.
  function automatic int ref_factor(input int code);
    case (code)
      0: return 2;   1: return 4;   2: return 6;   3: return 8;
      4: return 10;  5: return 12;  6: return 14;  7: return 16;
      8: return 1;   9: return 3;   10: return 5;  11: return 7;
      default: return 0;
    endcase
  endfunction

  // Behavioural model: per lane, a position inside the running period.
  int pos [2];
  int fac [2];
  bit run [2];
  bit e_lvl [2];
  bit e_rise [2];
  bit e_bad [2];

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (!rst_n) begin
        run[l] = 0; pos[l] = 0; fac[l] = 0;
        e_lvl[l] = 0; e_rise[l] = 0; e_bad[l] = 0;
      end else begin
        int code;
        code = (l == 0) ? int'(presc_cfg[7:4]) : int'(presc_cfg[3:0]);
        if (!run[l] || pos[l] == fac[l] - 1) begin
          // R7: code taken only when idle or at the end of a period
          int f;
          f = ref_factor(code);
          if (f == 0) run[l] = 0;
          else begin run[l] = 1; fac[l] = f; pos[l] = 0; end
        end else begin
          pos[l]++;
        end
        e_lvl[l]  = run[l] && (pos[l] < ((fac[l] == 1) ? 1 : fac[l] / 2));
        e_rise[l] = run[l] && (pos[l] == 0);
        e_bad[l]  = !run[l];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "lane A level", int'(aclk_a), int'(e_lvl[0]));
      chk(cur_req, "lane B level", int'(aclk_b), int'(e_lvl[1]));
      chk("R8", "lane A strobe", int'(aclk_a_rise), int'(e_rise[0]));
      chk("R8", "lane B strobe", int'(aclk_b_rise), int'(e_rise[1]));
      chk("R6", "lane A flag", int'(aclk_a_bad), int'(e_bad[0]));
      chk("R6", "lane B flag", int'(aclk_b_bad), int'(e_bad[1]));
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [7:0] v, input string req);
    @(negedge clk);
    presc_cfg = v;
    cur_req   = req;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int highs;
    cur_req = "R1";
    run_cycles(4);
    rst_n = 1'b1;
    set_cfg(8'h00, "R3");           // both lanes divide by 2
    run_cycles(20);
    set_cfg(8'h17, "R2");           // A /4, B /16: independent fields
    run_cycles(48);
    set_cfg(8'h70, "R3");           // A /16, B /2
    run_cycles(20);
    set_cfg(8'h00, "R7");           // mid-period change on lane A
    run_cycles(30);
    set_cfg(8'h88, "R4");           // divide by 1 on both lanes
    run_cycles(12);
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      highs += int'(aclk_b) + int'(aclk_b_rise);
    end
    chk("R4", "lane B high+strobe over 6 cycles", highs, 12);
    set_cfg(8'h9A, "R5");           // A /3, B /5
    run_cycles(40);
    set_cfg(8'hB9, "R5");           // A /7, B /3
    run_cycles(20);
    do @(negedge clk); while (!aclk_a_rise);
    highs = int'(aclk_a);
    for (int i = 1; i < 7; i++) begin
      @(negedge clk);
      highs += int'(aclk_a);
    end
    chk("R5", "lane A high cycles per /7 period", highs, 3);
    do @(negedge clk); while (!aclk_b_rise);
    highs = int'(aclk_b);
    for (int i = 1; i < 3; i++) begin
      @(negedge clk);
      highs += int'(aclk_b);
    end
    chk("R5", "lane B high cycles per /3 period", highs, 1);
    set_cfg(8'hC5, "R6");           // A not valid, B /12
    run_cycles(30);
    set_cfg(8'hFE, "R6");           // both not valid
    run_cycles(12);
    chk("R6", "lane A flag while held", int'(aclk_a_bad), 1);
    set_cfg(8'h3B, "R6");           // recover: A /8, B /7
    run_cycles(40);
    rst_n = 1'b0;
    cur_req = "R1";
    run_cycles(3);
    chk("R1", "lane A level in reset", int'(aclk_a), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule